// File: doc/BRIEF.md
# Memory Region Scoreboard

This block sits beside a processor pipeline and a reconfigurable compute array. Each array operation reads one memory region and writes another, and runs on its own while the processor keeps executing. A region is a power-of-two block of bytes. It is given by a base address and a size exponent. Address bits below the exponent are ignored, so every region is aligned.

The scoreboard keeps one entry for each array operation in flight. It compares every processor load and store with the regions those entries hold. A load that reads a region still waiting to be written is held. A store that writes a region still being read or written is held. Any other access passes with no delay. The ordering seen by software is therefore the same as program order.

A new array operation is held in three cases:
- every entry is in use;
- its function number is outside the loaded set;
- its source overlaps the destination of an operation still in flight.

A completion pulse names an entry, and that entry is freed at the next clock edge. For each loaded function, the block also reports whether any operation in flight uses it.

Top module: `region_scoreboard`

## Requirements
- R1: After reset no entry is in use, `busy_map` and `fn_busy` are zero, no access is stalled, and a legal new operation sees `op_ready` high.
- R2: When `op_valid` and `op_ready` are both high, the operation is placed in the lowest-numbered free entry. `op_idx` shows that entry in the same cycle. The matching `busy_map` bit is set from the next cycle.
- R3: While all entries are in use, `op_ready` is low.
- R4: A load (`mem_write`=0) is stalled when `mem_addr` lies in the destination region of an entry in use. An address lies in a region when it equals the base on every bit at or above the size exponent. Base bits below the exponent are ignored.
- R5: A load that falls only in the source region of an entry in use is not stalled.
- R6: A store (`mem_write`=1) is stalled when its address lies in the source region or the destination region of an entry in use.
- R7: `mem_stall` is low when `mem_valid` is low, and also when the address lies in no tracked region.
- R8: A new operation is refused (`op_ready` low) while its source region overlaps the destination region of an entry in use. Two aligned regions overlap when their bases match above the larger of the two size exponents. It is accepted again once that entry is freed.
- R9: A `done_valid` pulse that names an entry in use frees that entry at the next edge, which also removes any stall that entry caused. A pulse that names a free entry changes nothing.
- R10: Function numbers 0 to 13 are legal. An operation with a function number of 14 or more is refused.
- R11: Bit f of `fn_busy` is high exactly while at least one entry in use carries function f.
- R12: A region with size exponent k covers exactly 2^k bytes. Base + 2^k − 1 is inside the region; base + 2^k and base − 1 are outside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A new array operation is offered |
| op_func | input | 4 | Function number of the offered operation |
| op_src_base | input | 32 | Source region base address |
| op_src_lg | input | 5 | Source region size exponent |
| op_dst_base | input | 32 | Destination region base address |
| op_dst_lg | input | 5 | Destination region size exponent |
| op_ready | output | 1 | The offered operation can be accepted this cycle |
| op_idx | output | 2 | Entry the offered operation would take |
| done_valid | input | 1 | An array operation has completed |
| done_idx | input | 2 | Entry of the completed operation |
| mem_valid | input | 1 | A processor access is presented |
| mem_write | input | 1 | 1 = store, 0 = load |
| mem_addr | input | 32 | Byte address of the processor access |
| mem_stall | output | 1 | Hold the processor access |
| busy_map | output | 4 | One bit per entry in use |
| fn_busy | output | 14 | One bit per function with an operation in flight |

## Verification
The bench probes the edges of each region: the last byte inside, the first byte past the end, and a base with low bits set that must be masked off. A design that got the mask wrong by one bit would stall too much or too little at exactly these addresses. The bench also checks the overlap rule in both directions, with a small source inside a larger destination and a larger source around a smaller one. A design that masked with the wrong exponent would let a read-after-write hazard through. Completion is checked on the cycle it takes effect and on an entry that is already free. Two entries share one function, so a design that cleared a function's busy bit on the first completion would be caught.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
   typedef enum logic {
      ACC_LOAD  = 1'b0,
      ACC_STORE = 1'b1
   } acc_kind_e;

   // mask keeping address bits at or above lg (64 bits, caller truncates)
   function automatic logic [63:0] span_mask(input int unsigned lg);
      logic [63:0] one;
      one = 64'd1;
      if (lg >= 64) return 64'd0;
      return ~((one << lg) - 64'd1);
   endfunction
endpackage

// File: rtl/rsb_region_hit.sv
module rsb_region_hit #(
   parameter int AW = 32,
   parameter int LW = 5
) (
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] base,
   input  logic [LW-1:0] lg,
   output logic          hit
);
   logic [63:0]   mask64;
   logic [AW-1:0] mask;

   always_comb begin
      mask64 = rsb_pkg::span_mask(int'(lg));
      mask   = mask64[AW-1:0];
      hit    = ((addr ^ base) & mask) == '0;
   end
endmodule

// File: rtl/rsb_region_overlap.sv
module rsb_region_overlap #(
   parameter int AW = 32,
   parameter int LW = 5
) (
   input  logic [AW-1:0] a_base,
   input  logic [LW-1:0] a_lg,
   input  logic [AW-1:0] b_base,
   input  logic [LW-1:0] b_lg,
   output logic          overlap
);
   logic [LW-1:0] big_lg;
   logic [63:0]   mask64;
   logic [AW-1:0] mask;

   always_comb begin
      big_lg  = (a_lg > b_lg) ? a_lg : b_lg;
      mask64  = rsb_pkg::span_mask(int'(big_lg));
      mask    = mask64[AW-1:0];
      overlap = ((a_base ^ b_base) & mask) == '0;
   end
endmodule

// File: rtl/rsb_alloc.sv
module rsb_alloc #(
   parameter int N  = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  busy,
   output logic          free_any,
   output logic [IW-1:0] free_idx
);
   always_comb begin
      free_any = 1'b0;
      free_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!busy[i]) begin
            free_any = 1'b1;
            free_idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/region_scoreboard.sv
module region_scoreboard #(
   parameter int AW        = 32,
   parameter int LW        = 5,
   parameter int N         = 4,
   parameter int FW        = 4,
   parameter int NUM_FUNCS = 14,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 op_valid,
   input  logic [FW-1:0]        op_func,
   input  logic [AW-1:0]        op_src_base,
   input  logic [LW-1:0]        op_src_lg,
   input  logic [AW-1:0]        op_dst_base,
   input  logic [LW-1:0]        op_dst_lg,
   output logic                 op_ready,
   output logic [IW-1:0]        op_idx,
   input  logic                 done_valid,
   input  logic [IW-1:0]        done_idx,
   input  logic                 mem_valid,
   input  logic                 mem_write,
   input  logic [AW-1:0]        mem_addr,
   output logic                 mem_stall,
   output logic [N-1:0]         busy_map,
   output logic [NUM_FUNCS-1:0] fn_busy
);
   // elaboration-time parameter checks
   generate
      if (N < 2) begin : g_bad_n
         $error("region_scoreboard: N must be at least 2");
      end
      if (NUM_FUNCS > (1 << FW)) begin : g_bad_fn
         $error("region_scoreboard: NUM_FUNCS does not fit in FW bits");
      end
      if ((1 << LW) < AW) begin : g_bad_lw
         $error("region_scoreboard: LW too narrow to size a region");
      end
   endgenerate

   logic [N-1:0]  busy_q;
   logic [AW-1:0] src_base_q [N];
   logic [LW-1:0] src_lg_q   [N];
   logic [AW-1:0] dst_base_q [N];
   logic [LW-1:0] dst_lg_q   [N];
   logic [FW-1:0] func_q     [N];

   logic [N-1:0] src_hit, dst_hit, raw_conflict;
   logic          free_any;
   logic [IW-1:0] free_idx;
   logic          fn_legal, accept, free_ok;

   // per-entry comparators
   genvar e;
   generate
      for (e = 0; e < N; e++) begin : g_ent
         rsb_region_hit #(.AW(AW), .LW(LW)) u_src_hit (
            .addr(mem_addr), .base(src_base_q[e]), .lg(src_lg_q[e]),
            .hit(src_hit[e]));
         rsb_region_hit #(.AW(AW), .LW(LW)) u_dst_hit (
            .addr(mem_addr), .base(dst_base_q[e]), .lg(dst_lg_q[e]),
            .hit(dst_hit[e]));
         rsb_region_overlap #(.AW(AW), .LW(LW)) u_raw (
            .a_base(op_src_base), .a_lg(op_src_lg),
            .b_base(dst_base_q[e]), .b_lg(dst_lg_q[e]),
            .overlap(raw_conflict[e]));
      end
   endgenerate

   rsb_alloc #(.N(N)) u_alloc (
      .busy(busy_q), .free_any(free_any), .free_idx(free_idx));

   always_comb begin
      fn_legal = int'(op_func) < NUM_FUNCS;
      op_ready = free_any && fn_legal && ((raw_conflict & busy_q) == '0);
      op_idx   = free_idx;
      accept   = op_valid && op_ready;
      free_ok  = done_valid && (int'(done_idx) < N);
   end

   // processor access check
   always_comb begin
      mem_stall = 1'b0;
      if (mem_valid) begin
         if (rsb_pkg::acc_kind_e'(mem_write) == rsb_pkg::ACC_STORE)
            mem_stall = ((src_hit | dst_hit) & busy_q) != '0;
         else
            mem_stall = (dst_hit & busy_q) != '0;
      end
   end

   // entry state
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= '0;
         for (int i = 0; i < N; i++) begin
            src_base_q[i] <= '0;
            src_lg_q[i]   <= '0;
            dst_base_q[i] <= '0;
            dst_lg_q[i]   <= '0;
            func_q[i]     <= '0;
         end
      end else begin
         if (free_ok && busy_q[done_idx])
            busy_q[done_idx] <= 1'b0;
         if (accept) begin
            busy_q[free_idx]     <= 1'b1;
            src_base_q[free_idx] <= op_src_base;
            src_lg_q[free_idx]   <= op_src_lg;
            dst_base_q[free_idx] <= op_dst_base;
            dst_lg_q[free_idx]   <= op_dst_lg;
            func_q[free_idx]     <= op_func;
         end
      end
   end

   // function usage
   always_comb begin
      fn_busy = '0;
      for (int f = 0; f < NUM_FUNCS; f++)
         for (int i = 0; i < N; i++)
            if (busy_q[i] && func_q[i] == FW'(f))
               fn_busy[f] = 1'b1;
   end

   assign busy_map = busy_q;

   // assertions
   assert_full_refuses_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (&busy_map) |-> !op_ready);

   assert_accept_marks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_ready) |=> busy_map[$past(op_idx)]);

   assert_done_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && busy_map[done_idx] && !(op_valid && op_ready))
         |=> !busy_map[$past(done_idx)]);

   assert_idle_no_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_valid |-> !mem_stall);

   assert_bad_func_refused_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(op_func) >= NUM_FUNCS) |-> !op_ready);

   assert_fn_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_map == '0) |-> (fn_busy == '0));

   assert_empty_no_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_map == '0) |-> !mem_stall);
endmodule

// File: tb/region_scoreboard_bench.sv
module region_scoreboard_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        op_valid;
   logic [3:0]  op_func;
   logic [31:0] op_src_base, op_dst_base;
   logic [4:0]  op_src_lg, op_dst_lg;
   logic        op_ready;
   logic [1:0]  op_idx;
   logic        done_valid;
   logic [1:0]  done_idx;
   logic        mem_valid, mem_write;
   logic [31:0] mem_addr;
   logic        mem_stall;
   logic [3:0]  busy_map;
   logic [13:0] fn_busy;

   int checks = 0;
   int fails  = 0;
   bit timed_out = 1'b0;

   always #4 clk = ~clk;

   region_scoreboard u_region_scoreboard (
      .clk(clk), .rst_n(rst_n),
      .op_valid(op_valid), .op_func(op_func),
      .op_src_base(op_src_base), .op_src_lg(op_src_lg),
      .op_dst_base(op_dst_base), .op_dst_lg(op_dst_lg),
      .op_ready(op_ready), .op_idx(op_idx),
      .done_valid(done_valid), .done_idx(done_idx),
      .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
      .mem_stall(mem_stall), .busy_map(busy_map), .fn_busy(fn_busy));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // present an access and check the stall (combinational)
   task automatic probe(input string tag, input logic wr, input logic [31:0] a, input logic exp);
      @(negedge clk);
      mem_valid = 1'b1; mem_write = wr; mem_addr = a;
      #1 check(tag, {31'd0, mem_stall}, {31'd0, exp});
      mem_valid = 1'b0;
   endtask

   // offer an op without accepting it; report ready
   task automatic offer(input string tag, input logic [3:0] f, input logic [31:0] sb,
                        input logic [4:0] sl, input logic exp);
      @(negedge clk);
      op_valid = 1'b0; op_func = f;
      op_src_base = sb; op_src_lg = sl; op_dst_base = 32'hF000_0000; op_dst_lg = 5'd4;
      #1 check(tag, {31'd0, op_ready}, {31'd0, exp});
   endtask

   // issue an op and check the entry it takes
   task automatic issue(input string tag, input logic [3:0] f, input logic [31:0] sb,
                        input logic [4:0] sl, input logic [31:0] db, input logic [4:0] dl,
                        input logic [1:0] exp_idx);
      @(negedge clk);
      op_valid = 1'b1; op_func = f;
      op_src_base = sb; op_src_lg = sl; op_dst_base = db; op_dst_lg = dl;
      #1 check({tag, " ready"}, {31'd0, op_ready}, 32'd1);
      check({tag, " idx"}, {30'd0, op_idx}, {30'd0, exp_idx});
      @(posedge clk);
      #1 op_valid = 1'b0;
   endtask

   task automatic retire(input logic [1:0] i);
      @(negedge clk);
      done_valid = 1'b1; done_idx = i;
      @(posedge clk);
      #1 done_valid = 1'b0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      #1 check("R1 busy_map", {28'd0, busy_map}, 32'd0);
      check("R1 fn_busy", {18'd0, fn_busy}, 32'd0);
      probe("R1 no stall", 1'b1, 32'h0000_2000, 1'b0);
      offer("R1 ready", 4'd1, 32'h100, 5'd4, 1'b1);
   endtask

   task automatic t_regions;
      // entry0: func3, src 0x1000/256B, dst base 0x2005 (low bits ignored) /64B
      issue("R2 first", 4'd3, 32'h1000, 5'd8, 32'h2005, 5'd6, 2'd0);
      @(negedge clk);
      #1 check("R2 busy after", {28'd0, busy_map}, 32'h1);
      check("R11 fn3", {18'd0, fn_busy}, 32'h8);
      probe("R4 load dst base", 1'b0, 32'h2000, 1'b1);
      probe("R12 last byte", 1'b0, 32'h203F, 1'b1);
      probe("R12 past end", 1'b0, 32'h2040, 1'b0);
      probe("R12 below base", 1'b0, 32'h1FFF_FFFF & 32'h1FFF, 1'b0);
      probe("R5 load src", 1'b0, 32'h1080, 1'b0);
      probe("R6 store src", 1'b1, 32'h1080, 1'b1);
      probe("R6 store dst", 1'b1, 32'h2010, 1'b1);
      probe("R7 store elsewhere", 1'b1, 32'h3000, 1'b0);
      @(negedge clk);
      mem_valid = 1'b0; mem_write = 1'b0; mem_addr = 32'h2000;
      #1 check("R7 not valid", {31'd0, mem_stall}, 32'd0);
   endtask

   task automatic t_raw;
      offer("R8 small src inside dst", 4'd2, 32'h2010, 5'd4, 1'b0);
      offer("R8 large src around dst", 4'd2, 32'h2060, 5'd7, 1'b0);
      offer("R8 adjacent src ok", 4'd2, 32'h2040, 5'd6, 1'b1);
      offer("R10 func14 refused", 4'd14, 32'h8000, 5'd4, 1'b0);
      offer("R10 func13 ok", 4'd13, 32'h8000, 5'd4, 1'b1);
   endtask

   task automatic t_fill_and_free;
      issue("R2 second", 4'd13, 32'h4000, 5'd4, 32'h5000, 5'd4, 2'd1);
      issue("R2 third", 4'd3, 32'h4100, 5'd4, 32'h5100, 5'd4, 2'd2);
      issue("R2 fourth", 4'd0, 32'h4200, 5'd4, 32'h5200, 5'd4, 2'd3);
      @(negedge clk);
      #1 check("R3 all busy", {28'd0, busy_map}, 32'hF);
      check("R11 fn set", {18'd0, fn_busy}, 32'h2009);
      offer("R3 full refuses", 4'd1, 32'h9000, 5'd4, 1'b0);
      retire(2'd1);
      @(negedge clk);
      #1 check("R9 freed 1", {28'd0, busy_map}, 32'hD);
      check("R11 fn13 clear", {18'd0, fn_busy}, 32'h0009);
      offer("R2 lowest free ready", 4'd1, 32'h9000, 5'd4, 1'b1);
      check("R2 lowest free idx", {30'd0, op_idx}, 32'd1);
      retire(2'd1);
      @(negedge clk);
      #1 check("R9 idle done ignored", {28'd0, busy_map}, 32'hD);
      retire(2'd0);
      probe("R9 stall lifted", 1'b0, 32'h2000, 1'b0);
      @(negedge clk);
      #1 check("R11 fn3 still held", {18'd0, fn_busy}, 32'h0009);
      retire(2'd2);
      @(negedge clk);
      #1 check("R11 fn3 clear", {18'd0, fn_busy}, 32'h0001);
      retire(2'd3);
      @(negedge clk);
      #1 check("R9 all free", {28'd0, busy_map}, 32'h0);
   endtask

   task automatic t_raw_release;
      issue("R8 producer", 4'd5, 32'hA000, 5'd4, 32'h6000, 5'd5, 2'd0);
      offer("R8 consumer held", 4'd6, 32'h6010, 5'd2, 1'b0);
      @(negedge clk);
      done_valid = 1'b1; done_idx = 2'd0;
      #1 check("R8 held until edge", {31'd0, op_ready}, 32'd0);
      @(posedge clk);
      #1 done_valid = 1'b0;
      offer("R8 consumer released", 4'd6, 32'h6010, 5'd2, 1'b1);
   endtask

   initial begin
      #1_000_000;
      timed_out = 1'b1;
   end

   initial begin
      rst_n = 1'b0;
      op_valid = 1'b0; op_func = '0; op_src_base = '0; op_src_lg = '0;
      op_dst_base = '0; op_dst_lg = '0;
      done_valid = 1'b0; done_idx = '0;
      mem_valid = 1'b0; mem_write = 1'b0; mem_addr = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      fork
         begin
            t_reset();
            t_regions();
            t_raw();
            t_fill_and_free();
            t_raw_release();
         end
         begin
            wait (timed_out);
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule